// File: doc/BRIEF.md
# Fast Position Estimator with Deviation Monitor

This block keeps a drive's fast position and velocity usable when single feedback frames go bad. Each frame strobe brings either a received position or a fault indication. A frame is faulty when the encoder flags its sample as not valid or when the link reports a CRC or encoding error. A good frame loads the position and derives the velocity. A faulty frame extrapolates the position from the last good velocity and raises the estimating flag.

While it estimates, the block tracks how far the true position may have drifted. The drift bound is driven by a maximum-acceleration byte holding a 2-bit resolution selector and a 6-bit mantissa. Each estimated frame adds the decoded limit to a velocity-uncertainty sum, and then adds that sum to a position-uncertainty sum. The position-uncertainty sum is compared with a maximum-deviation value that is given in position units. Estimation has no time limit of its own; only the deviation flag reports that the uncertainty has grown too large.

Top module: `pos_estimator`

## Requirements
- R1: `pos_o` is 40 bits wide with the measured position right-justified in the low POS_BITS bits (default 24); bits 39:POS_BITS always read zero, even when `pos_i` carries ones there.
- R2: A good frame (`frame_i`=1, `pos_valid_i`=1, `crc_err_i`=0) loads `pos_o` with `pos_i[POS_BITS-1:0]`. It sets `vel_o` to that value minus the previous good position, modulo 2^POS_BITS, as two's complement; the previous good position is 0 after reset. It clears `est_on_o`. Outputs change on the clock edge that samples the strobe.
- R3: A faulty frame (`frame_i`=1 with `pos_valid_i`=0 or `crc_err_i`=1) sets `est_on_o`=1. It advances `pos_o` by `vel_o` modulo 2^POS_BITS and leaves `vel_o` unchanged.
- R4: While `frame_i`=0, `pos_valid_i` and `crc_err_i` have no effect: all outputs hold.
- R5: The acceleration limit, in units of 1/256 position LSB per frame², is `max_acc_i[5:0]` shifted left by 2×`max_acc_i[7:6]`. So selector 00 means ÷256, 01 means ÷64, 10 means ÷16 and 11 means ÷4.
- R6: On each faulty frame the velocity sum V becomes V+limit and the position sum P becomes P+V(new). `dev_thr_err_o` rises when the new P is strictly greater than `max_dev_i`×256.
- R7: `dev_thr_err_o` and `est_on_o` stay set across any number of faulty frames and clear only on a good frame, which also zeroes both sums.
- R8: `est_cnt_o` counts consecutive faulty frames, saturates at 2^CNT_W−1 (15 by default) and clears on a good frame.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle frame strobe |
| pos_i | input | 40 | Received position, right-justified |
| pos_valid_i | input | 1 | 0 = encoder marked the sample not valid |
| crc_err_i | input | 1 | 1 = CRC or encoding error on the position |
| max_dev_i | input | DEV_W (16) | Maximum deviation, position LSBs |
| max_acc_i | input | 8 | Acceleration limit: [7:6] resolution, [5:0] mantissa |
| pos_o | output | 40 | Fast position, real or estimated |
| vel_o | output | POS_BITS (24) | Velocity, position LSBs per frame, two's complement |
| est_on_o | output | 1 | Estimator active |
| dev_thr_err_o | output | 1 | Uncertainty exceeded maximum deviation |
| est_cnt_o | output | CNT_W (4) | Consecutive estimated frames, saturating |

## Verification
Every result goes through one register stage. Whatever the strobe presents is visible from the clock edge that samples it, and nothing combinational reaches the outputs. The bench drives the strobe and its flags at a falling edge and drops them at the next falling edge. It reads the outputs at that same falling edge, half a period after the update. The deviation flag is checked after every faulty frame in a run, so the frame count at which it rises is compared with the value worked out from the triangular sum for each acceleration code.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    FR_NONE = 2'd0,
    FR_GOOD = 2'd1,
    FR_EST  = 2'd2
  } frame_kind_e;

  // limit in 1/256 LSB units: mantissa << (2*sel)
  function automatic logic [11:0] acc_limit(input logic [7:0] code);
    logic [11:0] m;
    m = {6'd0, code[5:0]};
    return m << {code[7:6], 1'b0};
  endfunction
endpackage

// File: rtl/pe_frame_class.sv
module pe_frame_class
  import pe_pkg::*;
(
  input  logic        frame_i,
  input  logic        pos_valid_i,
  input  logic        crc_err_i,
  output frame_kind_e kind_o
);
  always_comb begin
    if (!frame_i)                       kind_o = FR_NONE;
    else if (pos_valid_i && !crc_err_i) kind_o = FR_GOOD;
    else                                kind_o = FR_EST;
  end
endmodule

// File: rtl/pe_track.sv
module pe_track
  import pe_pkg::*;
#(
  parameter int POS_BITS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  frame_kind_e         kind_i,
  input  logic [POS_BITS-1:0] pos_i,
  output logic [POS_BITS-1:0] pos_o,
  output logic [POS_BITS-1:0] vel_o,
  output logic                est_on_o
);
  logic [POS_BITS-1:0] pos_q, last_q, vel_q;
  logic                est_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      last_q <= '0;
      vel_q  <= '0;
      est_q  <= 1'b0;
    end else begin
      unique case (kind_i)
        FR_GOOD: begin
          pos_q  <= pos_i;
          vel_q  <= pos_i - last_q;
          last_q <= pos_i;
          est_q  <= 1'b0;
        end
        FR_EST: begin
          pos_q <= pos_q + vel_q;
          est_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pos_o    = pos_q;
  assign vel_o    = vel_q;
  assign est_on_o = est_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == FR_NONE |=> $stable(pos_q) && $stable(vel_q) && $stable(est_q));
  assert_good_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == FR_GOOD |=> !est_q && pos_q == $past(pos_i));
  assert_est_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == FR_EST |=> est_q && $stable(vel_q));
endmodule

// File: rtl/pe_uncert.sv
module pe_uncert
  import pe_pkg::*;
#(
  parameter int DEV_W = 16,
  parameter int CNT_W = 4,
  parameter int ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_kind_e      kind_i,
  input  logic [DEV_W-1:0] max_dev_i,
  input  logic [7:0]       max_acc_i,
  output logic             dev_err_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ACC_W-1:0] vacc_q, pacc_q, vacc_nx, pacc_nx, lim, thr;
  logic [ACC_W:0]   vsum, psum;
  logic             err_q;
  logic [CNT_W-1:0] cnt_q;

  assign lim  = ACC_W'(acc_limit(max_acc_i));
  assign thr  = ACC_W'({max_dev_i, 8'h00});
  assign vsum = {1'b0, vacc_q} + {1'b0, lim};
  assign vacc_nx = vsum[ACC_W] ? '1 : vsum[ACC_W-1:0];
  assign psum = {1'b0, pacc_q} + {1'b0, vacc_nx};
  assign pacc_nx = psum[ACC_W] ? '1 : psum[ACC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vacc_q <= '0;
      pacc_q <= '0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      unique case (kind_i)
        FR_GOOD: begin
          vacc_q <= '0;
          pacc_q <= '0;
          err_q  <= 1'b0;
          cnt_q  <= '0;
        end
        FR_EST: begin
          vacc_q <= vacc_nx;
          pacc_q <= pacc_nx;
          err_q  <= err_q | (pacc_nx > thr);
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign dev_err_o = err_q;
  assign cnt_o     = cnt_q;

  assert_zero_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == FR_EST && max_acc_i[5:0] == 6'd0 |=> vacc_q == $past(vacc_q));
  assert_pacc_grows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == FR_EST |=> pacc_q >= $past(pacc_q));
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && kind_i != FR_GOOD |=> err_q);
  assert_cnt_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX && kind_i == FR_EST |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/pos_estimator.sv
module pos_estimator
  import pe_pkg::*;
#(
  parameter int POS_W    = 40,
  parameter int POS_BITS = 24,
  parameter int DEV_W    = 16,
  parameter int CNT_W    = 4,
  parameter int ACC_W    = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                pos_valid_i,
  input  logic                crc_err_i,
  input  logic [DEV_W-1:0]    max_dev_i,
  input  logic [7:0]          max_acc_i,
  output logic [POS_W-1:0]    pos_o,
  output logic [POS_BITS-1:0] vel_o,
  output logic                est_on_o,
  output logic                dev_thr_err_o,
  output logic [CNT_W-1:0]    est_cnt_o
);
  localparam int PAD = POS_W - POS_BITS;

  frame_kind_e         kind;
  logic [POS_BITS-1:0] pos_meas;

  pe_frame_class u_class (
    .frame_i     (frame_i),
    .pos_valid_i (pos_valid_i),
    .crc_err_i   (crc_err_i),
    .kind_o      (kind)
  );

  pe_track #(.POS_BITS(POS_BITS)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .pos_i    (pos_i[POS_BITS-1:0]),
    .pos_o    (pos_meas),
    .vel_o    (vel_o),
    .est_on_o (est_on_o)
  );

  pe_uncert #(.DEV_W(DEV_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_uncert (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kind_i    (kind),
    .max_dev_i (max_dev_i),
    .max_acc_i (max_acc_i),
    .dev_err_o (dev_thr_err_o),
    .cnt_o     (est_cnt_o)
  );

  generate
    if (PAD > 0) begin : g_pad
      logic unused_pos_hi;
      assign unused_pos_hi = ^pos_i[POS_W-1:POS_BITS];
      assign pos_o = {{PAD{1'b0}}, pos_meas};
      assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_o[POS_W-1:POS_BITS] == '0);
    end else begin : g_full
      assign pos_o = pos_meas;
    end
  endgenerate
endmodule

// File: tb/pos_estimator_test.sv
module pos_estimator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic [39:0] pos_in = '0;
  logic        valid = 1'b1;
  logic        crc = 1'b0;
  logic [15:0] max_dev = '0;
  logic [7:0]  max_acc = '0;
  logic [39:0] pos;
  logic [23:0] vel;
  logic        est_on, dev_err;
  logic [3:0]  cnt;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pos_estimator uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .pos_i(pos_in),
    .pos_valid_i(valid), .crc_err_i(crc), .max_dev_i(max_dev),
    .max_acc_i(max_acc), .pos_o(pos), .vel_o(vel), .est_on_o(est_on),
    .dev_thr_err_o(dev_err), .est_cnt_o(cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe driven at a falling edge, results read at the next falling edge
  task automatic send(input logic [39:0] p, input logic v, input logic c);
    @(negedge clk);
    frame = 1'b1; pos_in = p; valid = v; crc = c;
    @(negedge clk);
    frame = 1'b0; valid = 1'b1; crc = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 pos", pos, 0); chk("R9 vel", vel, 0);
    chk("R9 est", est_on, 0); chk("R9 dev", dev_err, 0); chk("R9 cnt", cnt, 0);
  endtask

  task automatic t_track;
    send(40'd1000, 1, 0);
    chk("R2 pos", pos, 1000); chk("R2 vel from zero", vel, 1000);
    send(40'd1100, 1, 0);
    chk("R2 vel", vel, 100); chk("R2 est off", est_on, 0);
    send(40'd0, 0, 0);
    chk("R3 invalid pos", pos, 1200); chk("R3 est on", est_on, 1);
    chk("R3 vel held", vel, 100); chk("R8 cnt1", cnt, 1);
    send(40'd0, 1, 1);
    chk("R3 crc pos", pos, 1300); chk("R8 cnt2", cnt, 2);
    // flags without strobe
    @(negedge clk); valid = 1'b0; crc = 1'b1; pos_in = 40'd5;
    repeat (3) @(negedge clk);
    chk("R4 pos", pos, 1300); chk("R4 est", est_on, 1); chk("R4 cnt", cnt, 2);
    valid = 1'b1; crc = 1'b0;
    send(40'd1250, 1, 0);
    chk("R2 pos back", pos, 1250); chk("R2 vel vs last good", vel, 150);
    chk("R7 est cleared", est_on, 0); chk("R8 cnt cleared", cnt, 0);
  endtask

  task automatic t_wrap;
    send(40'hAB_00FF_FFE0, 1, 0);
    chk("R1 upper masked", pos, 40'hFF_FFE0);
    send(40'h00_00FF_FFF0, 1, 0);
    chk("R2 vel wrap", vel, 24'h10);
    send(40'd0, 0, 0);
    chk("R1 wrap zero", pos, 0);
    send(40'd0, 0, 0);
    chk("R1 wrap step", pos, 40'h10);
    send(40'd1000, 1, 0);
    send(40'd900, 1, 0);
    chk("R2 neg vel", vel, 24'hFFFF9C);
    send(40'd0, 1, 1);
    chk("R3 neg step", pos, 800);
  endtask

  // first faulty frame at which the flag must rise (0 = never within n)
  task automatic t_dev(input logic [7:0] acc, input logic [15:0] dev, input int rise, input int n);
    send(40'd500, 1, 0);
    max_acc = acc; max_dev = dev;
    for (int k = 1; k <= n; k++) begin
      send(40'd0, 0, 0);
      chk($sformatf("R6 acc=%0h frame %0d (R5 decode)", acc, k), dev_err,
          (rise != 0 && k >= rise) ? 1 : 0);
    end
    send(40'd500, 1, 0);
    chk("R7 dev cleared by good", dev_err, 0);
  endtask

  task automatic t_sat;
    send(40'd10, 1, 0);
    max_acc = 8'h01; max_dev = 16'hFFFF;
    for (int k = 1; k <= 20; k++) begin
      send(40'd0, 1, 1);
      chk($sformatf("R8 cnt frame %0d", k), cnt, (k > 15) ? 15 : k);
    end
    chk("R7 est still on", est_on, 1);
    chk("R6 no dev err", dev_err, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_track();
    t_wrap();
    t_dev(8'h44, 16'd1, 6, 8);   // 16/frame: 16,48,96,160,240,336
    t_dev(8'hC1, 16'd1, 3, 5);   // 64/frame: 64,192,384
    t_dev(8'h1B, 16'd1, 4, 6);   // 27/frame: 27,81,162,270
    t_dev(8'h00, 16'd0, 0, 6);   // zero limit never exceeds zero
    t_sat();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule